// File: doc/BRIEF.md
# Boundary Scan Test Access Port with Instruction Decoder

This block is the test access port of a memory device. A serial test clock and a mode-select line step a sixteen-state controller. A 3-bit instruction, shifted in serially, picks which data register sits between the serial input and the serial output. There are three choices: a 1-bit bypass stage, a 32-bit identification word, or a 107-bit boundary chain. The boundary chain takes a parallel snapshot of the device's I/O ring, and it hands a shifted-in pattern back to the ring through an update latch.

The opcode map is specific to this device. 000 drives the pins from the chain. 001 reads the identification word. 010 samples the ring and also forces every memory output driver to high impedance. 100 samples or preloads without disturbing the memory. 111 bypasses. The three remaining codes act as bypass, so the scan path always has a known length. The serial output changes on the falling test-clock edge. It is driven only while a shift state is active.

Top module: `tap_scan_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state test-port graph. Five rising test-clock edges with the mode-select line high bring it to the reset state from any state, and it stays there while the line stays high.
- R2: Driving the active-low test reset low forces the reset state and the identification instruction at once, without a clock edge.
- R3: While the controller is in the reset state, the current instruction is 001. A data scan that follows reset returns the identification word.
- R4: In the instruction capture state, the instruction shift stage loads 001. Instruction bits shift in least significant bit first and take effect at the instruction update state.
- R5: Opcodes 000, 010 and 100 select the 107-bit boundary chain. In the data capture state the chain loads `ring_in`, and `ring_in[0]` is the first bit out.
- R6: Opcode 001 selects a 32-bit identification word. Its layout is version in bits 31:29, device code in bits 28:12, vendor code in bits 11:1, and a constant 1 in bit 0. It is captured in the data capture state and shifted out bit 0 first.
- R7: Opcode 111 and the unused codes 011, 101 and 110 select the 1-bit bypass stage. This stage captures 0, so a scan returns a 0 followed by the input delayed by one clock.
- R8: `hiz_force` is high exactly while the current instruction is 010. `extest_en` is high exactly while it is 000. Neither output changes except at instruction update or reset.
- R9: In the data update state with the boundary chain selected, `bsr_q` takes the chain contents. With any other register selected, `bsr_q` holds.
- R10: `tdo` and `tdo_oe` change on the falling test-clock edge. `tdo_oe` is high only in the two shift states, so it is still low just after the rising edge that enters a shift state.
- R11: The data pause state holds the selected register. When the scan returns to the shift state, it continues with the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous active-low test reset (used when HAS_TRST=1) |
| ring_in | input | BSR_LEN | Parallel I/O ring values captured into the boundary chain |
| tdo | output | 1 | Serial data out, valid while tdo_oe is high |
| tdo_oe | output | 1 | Output enable for tdo; low means the pad floats |
| hiz_force | output | 1 | Forces the memory output drivers to high impedance |
| extest_en | output | 1 | Pins are driven from bsr_q |
| bsr_q | output | BSR_LEN | Boundary update latch contents |

## Verification
A wrong controller state shows up at the serial port within the same scan. The captured prefix is wrong, the bits arrive at the wrong offset, or `tdo_oe` is set at the wrong cycle. Every opcode is therefore scanned with a data length past the register length, so any error in path length or capture value moves the echoed input bits. A stale or corrupted instruction shows on `hiz_force` and `extest_en` one edge after instruction update. An update at the wrong moment shows on `bsr_q` as soon as the scan returns to idle.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

   localparam logic [2:0] OP_EXTEST  = 3'b000;
   localparam logic [2:0] OP_IDCODE  = 3'b001;
   localparam logic [2:0] OP_SAMPLEZ = 3'b010;
   localparam logic [2:0] OP_PRELOAD = 3'b100;
   localparam logic [2:0] OP_BYPASS  = 3'b111;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_scan_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e state_q, state_d;

   always_comb begin
      unique case (state_q)
         ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
         default:   state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RESET;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // checker: run length of consecutive high mode-select samples, saturating
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)             hi_run <= 3'd0;
      else if (!tms)          hi_run <= 3'd0;
      else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
   end

   AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (!rst_n)
      hi_run == 3'd5 |-> state_q == ST_RESET); // R1
   AST_RESET_STICKY: assert property (@(posedge tck) disable iff (!rst_n)
      (state_q == ST_RESET && tms) |=> state_q == ST_RESET); // R1

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_scan_pkg::*;
#(
   parameter int IR_W = 3
) (
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_cur,
   output logic            ir_lsb
);

   localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);
   localparam logic [IR_W-1:0] ID_OP   = IR_W'(OP_IDCODE);

   if (IR_W != 3) begin : g_bad_irw
      $error("tap_ir: opcode map needs IR_W == 3");
   end

   logic [IR_W-1:0] ir_sh, ir_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= '0;
         ir_q  <= ID_OP;
      end else begin
         unique case (state)
            ST_CAP_IR: ir_sh <= CAP_PAT;
            ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPD_IR: ir_q  <= ir_sh;
            ST_RESET:  ir_q  <= ID_OP;
            default:   ;
         endcase
      end
   end

   // the reset state overrides the latched instruction immediately
   assign ir_cur = (state == ST_RESET) ? ID_OP : ir_q;
   assign ir_lsb = ir_sh[0];

   AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
      state == ST_CAP_IR |=> ir_sh == CAP_PAT); // R4
   AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
      state == ST_RESET |=> ir_q == ID_OP); // R3
   AST_IR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
      (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q)); // R8

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_scan_pkg::*;
#(
   parameter int          BSR_LEN = 107,
   parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
   input  logic               tck,
   input  logic               rst_n,
   input  tap_state_e         state,
   input  dr_path_e           path,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] ring_in,
   output logic [BSR_LEN-1:0] bsr_q,
   output logic               dr_lsb
);

   if (BSR_LEN < 2) begin : g_bad_len
      $error("tap_dr: BSR_LEN must be at least 2");
   end
   if (ID_WORD[0] != 1'b1) begin : g_bad_id
      $error("tap_dr: identification word must end in 1");
   end

   logic               byp_q;
   logic [31:0]        id_sh;
   logic [BSR_LEN-1:0] bsr_sh;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         byp_q  <= 1'b0;
         id_sh  <= '0;
         bsr_sh <= '0;
         bsr_q  <= '0;
      end else begin
         unique case (state)
            ST_CAP_DR: begin
               unique case (path)
                  PATH_ID:  id_sh  <= ID_WORD;
                  PATH_BSR: bsr_sh <= ring_in;
                  default:  byp_q  <= 1'b0;
               endcase
            end
            ST_SH_DR: begin
               unique case (path)
                  PATH_ID:  id_sh  <= {tdi, id_sh[31:1]};
                  PATH_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
                  default:  byp_q  <= tdi;
               endcase
            end
            ST_UPD_DR: if (path == PATH_BSR) bsr_q <= bsr_sh;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (path)
         PATH_ID:  dr_lsb = id_sh[0];
         PATH_BSR: dr_lsb = bsr_sh[0];
         default:  dr_lsb = byp_q;
      endcase
   end

   AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_CAP_DR && path == PATH_BYP) |=> byp_q == 1'b0); // R7
   AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
      (state == ST_CAP_DR && path == PATH_ID) |=> id_sh[0] == 1'b1); // R6
   AST_BSR_UPDATE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
      !(state == ST_UPD_DR && path == PATH_BSR) |=> $stable(bsr_q)); // R9
   AST_PAUSE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
      state == ST_PAU_DR |=> ($stable(bsr_sh) && $stable(id_sh))); // R11

endmodule

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
   import tap_scan_pkg::*;
#(
   parameter bit          HAS_TRST   = 1'b1,
   parameter int          IR_W       = 3,
   parameter int          BSR_LEN    = 107,
   parameter logic [2:0]  ID_VERSION = 3'b000,
   parameter logic [16:0] ID_DEVICE  = 17'h1A2B3,
   parameter logic [10:0] ID_VENDOR  = 11'h0A5
) (
   input  logic               tck,
   input  logic               tms,
   input  logic               tdi,
   input  logic               trst_n,
   input  logic [BSR_LEN-1:0] ring_in,
   output logic               tdo,
   output logic               tdo_oe,
   output logic               hiz_force,
   output logic               extest_en,
   output logic [BSR_LEN-1:0] bsr_q
);

   localparam logic [31:0] ID_WORD = {ID_VERSION, ID_DEVICE, ID_VENDOR, 1'b1};

   logic rst_n;
   if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_e      state;
   logic [IR_W-1:0] ir_cur;
   logic            ir_lsb, dr_lsb;
   dr_path_e        path;

   tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

   tap_ir #(.IR_W(IR_W)) u_ir (
      .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
      .ir_cur(ir_cur), .ir_lsb(ir_lsb));

   always_comb begin
      unique case (ir_cur)
         OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD: path = PATH_BSR;
         OP_IDCODE:                         path = PATH_ID;
         default:                           path = PATH_BYP;
      endcase
   end

   tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
      .tck(tck), .rst_n(rst_n), .state(state), .path(path), .tdi(tdi),
      .ring_in(ring_in), .bsr_q(bsr_q), .dr_lsb(dr_lsb));

   assign hiz_force = (ir_cur == OP_SAMPLEZ);
   assign extest_en = (ir_cur == OP_EXTEST);

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
         tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
      end
   end

   AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR)); // R10

endmodule

// File: tb/tap_scan_ctrl_test.sv
module tap_scan_ctrl_test;

   localparam int          PERIOD = 10;
   localparam int          BLEN   = 107;
   localparam logic [2:0]  T_VER  = 3'b000;
   localparam logic [16:0] T_DEV  = 17'h0F3C5;
   localparam logic [10:0] T_VEN  = 11'h34B;
   localparam logic [31:0] T_ID   = {T_VER, T_DEV, T_VEN, 1'b1};

   logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
   logic [BLEN-1:0] ring_in = '0;
   logic tdo, tdo_oe, hiz_force, extest_en;
   logic [BLEN-1:0] bsr_q;

   int nchk = 0, nfail = 0;
   logic pre_oe;

   always #(PERIOD/2) tck = ~tck;

   tap_scan_ctrl #(.BSR_LEN(BLEN), .ID_VERSION(T_VER), .ID_DEVICE(T_DEV),
                   .ID_VENDOR(T_VEN)) uut (
      .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .ring_in(ring_in),
      .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force),
      .extest_en(extest_en), .bsr_q(bsr_q));

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one full clock: inputs set after a falling edge, sampled after the next one
   task automatic tick(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck); #1;
      pre_oe = tdo_oe;
      @(negedge tck); #1;
   endtask

   task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 3; i++) begin
         cap[i] = tdo;
         tick(i == 2, op[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic dr_scan(input logic [127:0] din, input int n, input int pause_at,
                          output logic [127:0] dout);
      dout = '0;
      tick(1, 0); tick(0, 0); tick(0, 0);
      chk(pre_oe == 1'b0 && tdo_oe == 1'b1, "R10 oe on falling edge",
          {126'b0, pre_oe, tdo_oe}, 128'b01);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tick((i == n-1) || (i == pause_at), din[i]);
         if (i == pause_at && i != n-1) begin
            tick(0, 0);
            chk(tdo_oe == 1'b0, "R11 oe low in pause", 128'(tdo_oe), 128'b0);
            tick(0, 1); tick(1, 0); tick(0, 0);
         end
      end
      tick(1, 0); tick(0, 0);
      chk(tdo_oe == 1'b0, "R10 oe low in idle", 128'(tdo_oe), 128'b0);
   endtask

   initial begin
      logic [127:0] din, dout, exp;
      logic [2:0]   cap;
      logic [BLEN-1:0] prev_q;
      int len, n;

      #(3*PERIOD + 2);
      trst_n = 1'b1;
      @(negedge tck); #1;
      chk(tdo_oe == 0 && hiz_force == 0 && extest_en == 0, "R2 reset outputs",
          {125'b0, tdo_oe, hiz_force, extest_en}, 128'b0);
      tick(0, 0);

      // R3 R6: data scan straight after reset returns the identification word
      din = {$urandom, $urandom, $urandom, $urandom};
      dr_scan(din, 40, -1, dout);
      exp = {88'b0, din[7:0], T_ID};
      chk(dout == exp, "R3 R6 id after reset", dout, exp);

      // sweep all eight opcodes
      for (int op = 0; op < 8; op++) begin
         ring_in = BLEN'({$urandom, $urandom, $urandom, $urandom});
         ir_scan(3'(op), cap);
         chk(cap == 3'b001, "R4 capture-IR pattern", 128'(cap), 128'b001);
         chk(hiz_force == (op == 2) && extest_en == (op == 0), "R8 mode outputs",
             {126'b0, hiz_force, extest_en}, {126'b0, op == 2, op == 0});
         prev_q = bsr_q;
         if (op == 0 || op == 2 || op == 4) begin
            len = BLEN; exp = 128'(ring_in);
         end else if (op == 1) begin
            len = 32;   exp = 128'(T_ID);
         end else begin
            len = 1;    exp = '0;
         end
         n = len + 8;
         din = {$urandom, $urandom, $urandom, $urandom};
         dr_scan(din, n, (op % 2 == 1) ? 5 : -1, dout);
         for (int i = 0; i < 8; i++) exp[len+i] = din[i];
         chk(dout == exp,
             (len == BLEN) ? "R5 boundary path" : (len == 32) ? "R6 id path" : "R7 bypass path",
             dout, exp);
         if (len == BLEN)
            chk(bsr_q == din[8 +: BLEN], "R9 update latch loads", 128'(bsr_q),
                128'(din[8 +: BLEN]));
         else
            chk(bsr_q == prev_q, "R9 update latch holds", 128'(bsr_q), 128'(prev_q));
      end

      // R1: five high mode-select clocks from Shift-DR reach reset
      ir_scan(3'b010, cap);
      chk(hiz_force == 1'b1, "R8 hiz set", 128'(hiz_force), 128'b1);
      tick(1, 0); tick(0, 0); tick(0, 0);
      chk(tdo_oe == 1'b1, "R1 in shift", 128'(tdo_oe), 128'b1);
      for (int i = 0; i < 5; i++) tick(1, 0);
      chk(hiz_force == 0 && tdo_oe == 0, "R1 five-high reset",
          {126'b0, hiz_force, tdo_oe}, 128'b0);
      tick(1, 0);
      chk(hiz_force == 0, "R1 reset sticky", 128'(hiz_force), 128'b0);
      tick(0, 0);
      din = {$urandom, $urandom, $urandom, $urandom};
      dr_scan(din, 40, -1, dout);
      exp = {88'b0, din[7:0], T_ID};
      chk(dout == exp, "R3 id after tms reset", dout, exp);

      // R2: asynchronous test reset
      ir_scan(3'b010, cap);
      chk(hiz_force == 1'b1, "R8 hiz set again", 128'(hiz_force), 128'b1);
      #(PERIOD/4);
      trst_n = 1'b0;
      #1;
      chk(hiz_force == 1'b0, "R2 async reset", 128'(hiz_force), 128'b0);
      @(negedge tck); #1;
      trst_n = 1'b1;
      tick(0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule